// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block is the sending half of a clocked synchronous serial link. A host loads a byte into a holding register through a write strobe and then releases it by pulsing a flag-clear strobe. The block copies the held byte into a shift register, reports the holding register as free again, and sends the byte on the data pin one bit per serial clock period, least significant bit first.

The serial clock is either generated inside the block from the system clock through a parameterised divider, or taken from an outside master through a synchronizer and edge detector. In both modes the data pin changes only on a falling serial clock edge, so a receiver samples on the rising edge. While the last bit of a frame goes out, the block looks at the empty flag once more: if a new byte is waiting, that byte follows with no idle period; if not, the transmit-end flag is raised and the line stays at its final level with the clock idle high. Two interrupt request outputs follow the flags, each gated by its own enable.

Top module: `sctx_serial_tx`

## Requirements
- R1: After reset the empty flag and the end flag are 1, the data output is 1 and the serial clock output is 1; with both enables at 0 both request outputs are 0.
- R2: A flag-clear strobe makes the empty flag read 0 in the following cycle; when idle, the block takes the held byte one cycle later and the empty flag reads 1 again.
- R3: The data-empty request equals the empty flag ANDed with its enable, and the end request equals the end flag ANDed with its enable, as levels.
- R4: In internal clock mode each frame has exactly 8 low pulses on the serial clock output, and the data output changes only while that clock is low.
- R5: Bits leave in order bit 0 first through bit 7 last, each valid on a rising serial clock edge.
- R6: If the empty flag is 0 while the last bit is on the line, the waiting byte follows at the next falling edge with no gap: rising edges keep the spacing of R10 across the frame boundary.
- R7: If the empty flag is 1 when the last bit starts, the end flag goes to 1; after that bit the data output keeps bit 7 and the serial clock output stays 1.
- R8: A flag-clear strobe sets the end flag to 0 in the same cycle it clears the empty flag.
- R9: In external clock mode the serial clock output is held at 1, the first falling edge of the incoming clock after a load starts bit 0, and each later falling edge advances one bit.
- R10: In internal clock mode successive rising serial clock edges within a run of frames are 2*HALF_DIV system clocks apart.
- R11: A write to the holding register alone starts no frame: no serial clock edge appears and the empty flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to hold |
| flag_clr | input | 1 | Clears the empty and end flags, releasing the held byte |
| tx_int_en | input | 1 | Enable for the data-empty request |
| end_int_en | input | 1 | Enable for the end request |
| ext_mode | input | 1 | 1 selects the incoming serial clock, 0 the internal divider |
| sclk_in | input | 1 | Serial clock from an outside master |
| sclk_out | output | 1 | Generated serial clock, idle high |
| sdata_out | output | 1 | Serial data |
| empty_flag | output | 1 | Holding register free |
| end_flag | output | 1 | Transmission finished with nothing waiting |
| txi_req | output | 1 | Data-empty interrupt request |
| tei_req | output | 1 | End interrupt request |

## Verification
The bench builds the block with HALF_DIV set to 2 and two synchronizer stages, so a full frame lasts 32 system clocks and single frames, back-to-back pairs and an externally clocked frame all fit in a short run. The small divider keeps the expected rising-edge spacing at 4 cycles, which makes a one-cycle gap at a frame boundary plainly visible. The external master is driven with a half period of 6 cycles, longer than the synchronizer delay, so the data bit is settled at each rising edge the master produces.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } tx_state_e;
endpackage

// File: rtl/sctx_clkgen.sv
module sctx_clkgen #(
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_mode,
   input  logic sclk_in,
   input  logic start,
   input  logic busy,
   output logic fall_ev,
   output logic sclk_out
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   initial begin
      assert (HALF_DIV >= 1) else $fatal(1, "HALF_DIV must be at least 1");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic half_tick;
   logic ph_q;

   generate
      if (HALF_DIV == 1) begin : g_div_bypass
         assign half_tick = busy;
      end else begin : g_div_cnt
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (start || !busy)   cnt_q <= '0;
            else if (cnt_q == LAST)    cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
         assign half_tick = busy && (cnt_q == LAST);
      end
   endgenerate

   logic int_tick;
   assign int_tick = half_tick && !ext_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ph_q <= 1'b1;
      else if (start)    ph_q <= 1'b0;
      else if (int_tick) ph_q <= ~ph_q;
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= sclk_in;
   end

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   logic ext_fall;
   logic int_fall;
   assign ext_fall = prev_q && !sync_q[SYNC_STAGES-1];
   assign int_fall = int_tick && ph_q;

   assign fall_ev  = ext_mode ? ext_fall : int_fall;
   assign sclk_out = ext_mode || ph_q || !busy;
endmodule

// File: rtl/sctx_shifter.sv
module sctx_shifter
   import sctx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              fall_ev,
   input  logic              empty,
   input  logic [DATA_W-1:0] tdr,
   output logic              take,
   output logic              start,
   output logic              last_ev,
   output logic              busy,
   output logic              sdata
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   initial begin
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
   end

   tx_state_e         state_q, state_n;
   logic [DATA_W-1:0] tsr_q, tsr_n;
   logic [IDX_W-1:0]  idx_q, idx_n;
   logic              sd_q, sd_n;

   always_comb begin
      state_n = state_q;
      tsr_n   = tsr_q;
      idx_n   = idx_q;
      sd_n    = sd_q;
      take    = 1'b0;
      start   = 1'b0;
      last_ev = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!empty) begin
               take    = 1'b1;
               start   = !ext_mode;
               tsr_n   = tdr >> 1;
               sd_n    = tdr[0];
               idx_n   = '0;
               state_n = ext_mode ? ST_ARM : ST_RUN;
            end
         end
         ST_ARM: begin
            if (fall_ev) state_n = ST_RUN;
         end
         ST_RUN: begin
            if (fall_ev) begin
               if (idx_q != LAST_IDX) begin
                  sd_n    = tsr_q[0];
                  tsr_n   = tsr_q >> 1;
                  idx_n   = idx_q + 1'b1;
                  last_ev = (idx_q + 1'b1) == LAST_IDX;
               end else if (!empty) begin
                  take  = 1'b1;
                  tsr_n = tdr >> 1;
                  sd_n  = tdr[0];
                  idx_n = '0;
               end else begin
                  state_n = ST_IDLE;
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tsr_q   <= '0;
         idx_q   <= '0;
         sd_q    <= 1'b1;
      end else begin
         state_q <= state_n;
         tsr_q   <= tsr_n;
         idx_q   <= idx_n;
         sd_q    <= sd_n;
      end
   end

   assign busy  = state_q != ST_IDLE;
   assign sdata = sd_q;
endmodule

// File: rtl/sctx_flags.sv
module sctx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flag_clr,
   input  logic              take,
   input  logic              last_ev,
   input  logic              tx_int_en,
   input  logic              end_int_en,
   output logic [DATA_W-1:0] tdr,
   output logic              empty,
   output logic              tx_end,
   output logic              txi_req,
   output logic              tei_req
);
   logic [DATA_W-1:0] tdr_q;
   logic              empty_q;
   logic              end_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tdr_q <= '0;
      else if (wr_en) tdr_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        empty_q <= 1'b1;
      else if (take)     empty_q <= 1'b1;
      else if (flag_clr) empty_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  end_q <= 1'b1;
      else if (flag_clr)           end_q <= 1'b0;
      else if (last_ev && empty_q) end_q <= 1'b1;
   end

   assign tdr     = tdr_q;
   assign empty   = empty_q;
   assign tx_end  = end_q;
   assign txi_req = empty_q && tx_int_en;
   assign tei_req = end_q && end_int_en;
endmodule

// File: rtl/sctx_serial_tx.sv
module sctx_serial_tx #(
   parameter int DATA_W      = 8,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flag_clr,
   input  logic              tx_int_en,
   input  logic              end_int_en,
   input  logic              ext_mode,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sdata_out,
   output logic              empty_flag,
   output logic              end_flag,
   output logic              txi_req,
   output logic              tei_req
);
   logic [DATA_W-1:0] tdr;
   logic take, start, last_ev, busy, fall_ev;

   sctx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .flag_clr   (flag_clr),
      .take       (take),
      .last_ev    (last_ev),
      .tx_int_en  (tx_int_en),
      .end_int_en (end_int_en),
      .tdr        (tdr),
      .empty      (empty_flag),
      .tx_end     (end_flag),
      .txi_req    (txi_req),
      .tei_req    (tei_req)
   );

   sctx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .fall_ev  (fall_ev),
      .empty    (empty_flag),
      .tdr      (tdr),
      .take     (take),
      .start    (start),
      .last_ev  (last_ev),
      .busy     (busy),
      .sdata    (sdata_out)
   );

   sctx_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .sclk_in  (sclk_in),
      .start    (start),
      .busy     (busy),
      .fall_ev  (fall_ev),
      .sclk_out (sclk_out)
   );
endmodule

// File: rtl/sctx_serial_tx_chk.sv
module sctx_serial_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic ext_mode,
   input logic tx_int_en,
   input logic sclk_out,
   input logic sdata_out,
   input logic empty_flag,
   input logic end_flag,
   input logic txi_req,
   input logic busy
);
   AST_END_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      end_flag |-> empty_flag);                                            // R7
   AST_TXI_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      txi_req |-> (empty_flag && tx_int_en));                              // R3
   AST_DATA_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && $past(!ext_mode) && sclk_out && $past(sclk_out)) |-> $stable(sdata_out)); // R4
   AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |-> !$past(empty_flag));                      // R11
   AST_EXT_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |-> sclk_out);                                              // R9
   AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk_out);                                                 // R7
endmodule

bind sctx_serial_tx sctx_serial_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_mode   (ext_mode),
   .tx_int_en  (tx_int_en),
   .sclk_out   (sclk_out),
   .sdata_out  (sdata_out),
   .empty_flag (empty_flag),
   .end_flag   (end_flag),
   .txi_req    (txi_req),
   .busy       (busy)
);

// File: tb/tb_sctx_serial_tx.sv
`timescale 1ns/1ps
module tb_sctx_serial_tx;
   localparam int HD = 2;
   localparam int EXT_HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic flag_clr = 1'b0;
   logic tx_int_en = 1'b0;
   logic end_int_en = 1'b0;
   logic ext_mode = 1'b0;
   logic sclk_in = 1'b1;
   logic sclk_out, sdata_out, empty_flag, end_flag, txi_req, tei_req;

   always #2 clk = ~clk;

   sctx_serial_tx #(.DATA_W(8), .HALF_DIV(HD), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .flag_clr(flag_clr), .tx_int_en(tx_int_en), .end_int_en(end_int_en),
      .ext_mode(ext_mode), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sdata_out(sdata_out), .empty_flag(empty_flag), .end_flag(end_flag),
      .txi_req(txi_req), .tei_req(tei_req));

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // receiver model, internal clock mode
   int cyc = 0;
   logic prev_sclk = 1'b1;
   int fall_cnt, rx_bits, rx_nbytes, last_rise, gap_min, gap_max;
   bit have_rise, ext_low_seen;
   logic [7:0] rx_shift;
   logic [7:0] rx_bytes [0:3];

   task automatic clear_mon();
      fall_cnt = 0; rx_bits = 0; rx_nbytes = 0; have_rise = 0;
      gap_min = 9999; gap_max = 0; ext_low_seen = 0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (ext_mode) begin
         if (!sclk_out) ext_low_seen = 1'b1;
      end else begin
         if (prev_sclk && !sclk_out) fall_cnt++;
         if (!prev_sclk && sclk_out) begin
            rx_shift = {sdata_out, rx_shift[7:1]};
            rx_bits++;
            if (rx_bits % 8 == 0 && rx_nbytes < 4) begin
               rx_bytes[rx_nbytes] = rx_shift;
               rx_nbytes++;
            end
            if (have_rise) begin
               if (cyc - last_rise > gap_max) gap_max = cyc - last_rise;
               if (cyc - last_rise < gap_min) gap_min = cyc - last_rise;
            end
            last_rise = cyc;
            have_rise = 1'b1;
         end
      end
      prev_sclk = sclk_out;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] d);
      wr_data = d; wr_en = 1'b1; tick(); wr_en = 1'b0;
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1; tick(); flag_clr = 1'b0;
   endtask

   task automatic wait_end();
      for (int i = 0; i < 2000 && !end_flag; i++) tick();
   endtask

   // {tx_int_en, end_int_en, data}
   localparam logic [9:0] VEC [6] = '{
      {2'b11, 8'hA5}, {2'b00, 8'h00}, {2'b10, 8'hFF},
      {2'b01, 8'h5A}, {2'b11, 8'h01}, {2'b01, 8'h80}
   };

   initial begin
      clear_mon();
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 empty", empty_flag, 1);
      chk("R1 end", end_flag, 1);
      chk("R1 sdata", sdata_out, 1);
      chk("R1 sclk", sclk_out, 1);
      chk("R1 txi off", txi_req, 0);
      chk("R1 tei off", tei_req, 0);
      // R3 level requests
      tx_int_en = 1'b1; end_int_en = 1'b1; #1;
      chk("R3 txi on", txi_req, 1);
      chk("R3 tei on", tei_req, 1);
      // R11 write alone starts nothing
      clear_mon();
      write_byte(8'hC3);
      tick(40);
      chk("R11 no falls", fall_cnt, 0);
      chk("R11 empty", empty_flag, 1);

      foreach (VEC[v]) begin
         logic [7:0] d;
         d = VEC[v][7:0];
         tx_int_en = VEC[v][9]; end_int_en = VEC[v][8];
         clear_mon();
         write_byte(d);
         flag_clr = 1'b1; tick(); flag_clr = 1'b0;
         chk("R2 empty cleared", empty_flag, 0);
         chk("R8 end cleared", end_flag, 0);
         tick();
         chk("R2 empty after take", empty_flag, 1);
         wait_end();
         tick(2 * HD + 3);
         chk("R5 byte", rx_nbytes == 1 ? int'(rx_bytes[0]) : -1, d);
         chk("R4 pulses", fall_cnt, 8);
         chk("R10 gap max", gap_max, 2 * HD);
         chk("R10 gap min", gap_min, 2 * HD);
         chk("R7 end", end_flag, 1);
         chk("R7 tei", tei_req, VEC[v][8]);
         chk("R3 txi", txi_req, VEC[v][9]);
         chk("R7 data holds", sdata_out, d[7]);
         chk("R7 sclk idle", sclk_out, 1);
      end

      // R6 back-to-back frames
      clear_mon();
      write_byte(8'h96);
      pulse_clr();
      tick(2);
      chk("R6 first taken", empty_flag, 1);
      write_byte(8'h4B);
      pulse_clr();
      wait_end();
      tick(2 * HD + 3);
      chk("R6 two bytes", rx_nbytes, 2);
      chk("R6 byte0", rx_bytes[0], 8'h96);
      chk("R6 byte1", rx_bytes[1], 8'h4B);
      chk("R6 pulses", fall_cnt, 16);
      chk("R6 no gap", gap_max, 2 * HD);

      // R9 external clock mode
      ext_mode = 1'b1;
      clear_mon();
      tick(2);
      write_byte(8'h3C);
      pulse_clr();
      tick(3);
      begin
         logic [7:0] got;
         got = '0;
         for (int b = 0; b < 8; b++) begin
            sclk_in = 1'b0; tick(EXT_HALF);
            got[b] = sdata_out;
            sclk_in = 1'b1; tick(EXT_HALF);
         end
         chk("R9 ext byte", got, 8'h3C);
      end
      tick(EXT_HALF);
      chk("R9 ext end", end_flag, 1);
      chk("R9 ext last bit", sdata_out, 0);
      chk("R9 ext sclk parked", ext_low_seen, 0);
      chk("R9 ext empty", empty_flag, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule